// File: doc/BRIEF.md
# Double-data-rate receive sample deframer

This block sits behind the capture flops of a source-synchronous double-data-rate receive link. Each interface clock it takes one 6-bit word captured on the rising edge, one 6-bit word captured on the falling edge, and the frame line as seen on each edge. Together the two halves make one 12-bit sample. A frame line that travels with the data splits the sample stream into four time-multiplexed channels: in-phase and quadrature for two receive paths.

The deframer locks onto the rising edge of the frame line and collects one sample per channel slot. When a whole frame is in, it releases all four channel words together with a one-cycle strobe. While it tracks, it checks every word against the expected frame pattern. On the first violation it drops the partial frame, sets a sticky flag and hunts for the next frame edge.

A separate self-seeding pseudo-random sequence monitor watches the raw sample stream, whether or not it is framed. Calibration uses it to find a good capture delay: software sweeps the delay, enables the monitor and reads back lock and a saturating mismatch count. All logic runs on the interface clock.

Top module: `rx_lvds_deframer`

## Requirements
- R1: A sample word is {rx_rise_i, rx_fall_i}: the rising-edge half forms bits [11:6] and the falling-edge half forms bits [5:0].
- R2: While not aligned, a word is taken as slot 0 (I0) only when both frame bits are 1 and the falling-edge frame bit of the previous word was 0. After reset, that previous bit counts as 1. All other words are discarded.
- R3: The slot order is I0, Q0, I1, Q1. The expected frame bits are 1 on both edges in slots 0 and 1, and 0 on both edges in slots 2 and 3. ch_data_o packs I0 in [11:0], Q0 in [23:12], I1 in [35:24] and Q1 in [47:36].
- R4: The cycle after the Q1 word is sampled, all four ch_valid_o bits are 1 for exactly one cycle. ch_data_o holds its value until the next complete frame.
- R5: While aligned, a word whose frame bits differ from the expected value sets misalign_o. misalign_o stays set until reset. The word causes alignment to be lost and the partial frame to be dropped without a strobe. Hunting per R2 starts from the following word.
- R6: align_o is 1 exactly while the block is aligned, from the cycle after the slot-0 word until the cycle after a frame violation.
- R7: While prbs_en_i is 1, each word after the first is compared with the previous word advanced 12 steps of a left-shifting LFSR. At each step the new bit 0 is the XOR of bits 11, 5, 3 and 0. prbs_lock_o rises after 16 consecutive matches.
- R8: A mismatch clears the match run and prbs_lock_o, and increments prbs_err_o. prbs_err_o saturates at 0xFFFF.
- R9: While prbs_en_i is 0, prbs_lock_o and prbs_err_o are cleared. The first word after enabling only seeds the comparison.
- R10: After reset, ch_valid_o, ch_data_o, align_o, misalign_o, prbs_lock_o and prbs_err_o are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Interface clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_rise_i | input | 6 | Data half captured on the rising edge |
| rx_fall_i | input | 6 | Data half captured on the falling edge |
| frame_rise_i | input | 1 | Frame line captured on the rising edge |
| frame_fall_i | input | 1 | Frame line captured on the falling edge |
| prbs_en_i | input | 1 | Sequence monitor enable |
| ch_data_o | output | 48 | Four channel samples, I0 in the low bits |
| ch_valid_o | output | 4 | Per-channel frame-complete strobe |
| align_o | output | 1 | Aligned to the frame |
| misalign_o | output | 1 | Sticky frame-violation flag |
| prbs_lock_o | output | 1 | Sequence monitor locked |
| prbs_err_o | output | 16 | Saturating mismatch count |

## Verification
Two cases are hard to reach from the ports. The first is error-count saturation, which needs more than 65535 mismatches without a disable in between. The stimulus holds the sample word at all ones for about 66000 cycles; that word never follows itself in the sequence, so every cycle counts. The second is a frame violation partway through an aligned frame. Directed words break slot 2, and the last frame word is given a half-sample frame edge. Randomly corrupted frame bits then mix violations, resyncs and clean frames.

// File: rtl/rx_deframe_pkg.sv
package rx_deframe_pkg;
  localparam int SMP_W_DEF    = 12;
  localparam int NUM_CH_DEF   = 4;
  localparam int LOCK_RUN_DEF = 16;
  localparam int ERR_W_DEF    = 16;
  localparam logic [11:0] PRBS_TAPS_DEF = 12'h829;

  typedef enum logic {ST_HUNT, ST_TRACK} align_st_e;
endpackage

// File: rtl/rx_frame_align.sv
module rx_frame_align
  import rx_deframe_pkg::*;
#(
  parameter int SMP_W  = SMP_W_DEF,
  parameter int NUM_CH = NUM_CH_DEF
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [SMP_W-1:0]        word_i,
  input  logic                    frame_rise_i,
  input  logic                    frame_fall_i,
  output logic [NUM_CH*SMP_W-1:0] data_o,
  output logic                    valid_o,
  output logic                    align_o,
  output logic                    misalign_o
);
  localparam int SLOT_W = $clog2(NUM_CH);
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(NUM_CH - 1);
  localparam logic [SLOT_W-1:0] HI_SLOTS  = SLOT_W'(NUM_CH / 2);

  align_st_e                 st_q;
  logic [SLOT_W-1:0]         slot_q;
  logic                      prev_fall_q;
  logic                      valid_q, misalign_q;
  logic [SMP_W-1:0]          buf_q [NUM_CH-1];
  logic [NUM_CH*SMP_W-1:0]   out_q;

  logic exp_hi, frame_ok, start;
  assign exp_hi   = (slot_q < HI_SLOTS);
  assign frame_ok = (frame_rise_i == exp_hi) && (frame_fall_i == exp_hi);
  // slot 0 needs a full-sample frame edge
  assign start    = frame_rise_i & frame_fall_i & ~prev_fall_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= ST_HUNT;
      slot_q      <= '0;
      prev_fall_q <= 1'b1;
      valid_q     <= 1'b0;
      misalign_q  <= 1'b0;
      out_q       <= '0;
      for (int i = 0; i < NUM_CH - 1; i++) buf_q[i] <= '0;
    end else begin
      prev_fall_q <= frame_fall_i;
      valid_q     <= 1'b0;
      if (st_q == ST_HUNT) begin
        if (start) begin
          st_q     <= ST_TRACK;
          buf_q[0] <= word_i;
          slot_q   <= SLOT_W'(1);
        end
      end else if (!frame_ok) begin
        st_q       <= ST_HUNT;
        slot_q     <= '0;
        misalign_q <= 1'b1;
      end else if (slot_q == LAST_SLOT) begin
        for (int i = 0; i < NUM_CH - 1; i++) out_q[i*SMP_W +: SMP_W] <= buf_q[i];
        out_q[(NUM_CH-1)*SMP_W +: SMP_W] <= word_i;
        valid_q <= 1'b1;
        slot_q  <= '0;
      end else begin
        buf_q[slot_q] <= word_i;
        slot_q        <= slot_q + SLOT_W'(1);
      end
    end
  end

  assign data_o     = out_q;
  assign valid_o    = valid_q;
  assign align_o    = (st_q == ST_TRACK);
  assign misalign_o = misalign_q;

  a_r4_valid_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q |=> !valid_q);
  a_r4_data_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_q |-> $stable(out_q));
  a_r5_misalign_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    misalign_q |=> misalign_q);
  a_r5_violation_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_TRACK && !frame_ok) |=> (st_q == ST_HUNT && misalign_q && !valid_q));
  a_r2_hunt_no_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_HUNT) |=> !valid_q);
endmodule

// File: rtl/rx_prbs_mon.sv
module rx_prbs_mon
  import rx_deframe_pkg::*;
#(
  parameter int             W        = SMP_W_DEF,
  parameter logic [W-1:0]   TAPS     = PRBS_TAPS_DEF,
  parameter int             LOCK_RUN = LOCK_RUN_DEF,
  parameter int             ERR_W    = ERR_W_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [W-1:0]     word_i,
  output logic             lock_o,
  output logic [ERR_W-1:0] err_o
);
  localparam int RUN_W = $clog2(LOCK_RUN + 1);
  localparam logic [RUN_W-1:0] RUN_MAX  = RUN_W'(LOCK_RUN);
  localparam logic [RUN_W-1:0] RUN_LAST = RUN_W'(LOCK_RUN - 1);
  localparam logic [ERR_W-1:0] ERR_MAX  = '1;

  function automatic logic [W-1:0] advance(input logic [W-1:0] s);
    logic [W-1:0] r;
    r = s;
    for (int k = 0; k < W; k++) r = {r[W-2:0], ^(r & TAPS)};
    return r;
  endfunction

  logic [W-1:0]     prev_q;
  logic             have_q, lock_q;
  logic [RUN_W-1:0] run_q;
  logic [ERR_W-1:0] err_q;
  logic             hit;

  assign hit = (word_i == advance(prev_q));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '0;
      have_q <= 1'b0;
      lock_q <= 1'b0;
      run_q  <= '0;
      err_q  <= '0;
    end else begin
      prev_q <= word_i;
      if (!en_i) begin
        have_q <= 1'b0;
        lock_q <= 1'b0;
        run_q  <= '0;
        err_q  <= '0;
      end else begin
        have_q <= 1'b1;
        if (have_q) begin
          if (hit) begin
            if (run_q != RUN_MAX) run_q <= run_q + RUN_W'(1);
            if (run_q >= RUN_LAST) lock_q <= 1'b1;
          end else begin
            run_q  <= '0;
            lock_q <= 1'b0;
            if (err_q != ERR_MAX) err_q <= err_q + ERR_W'(1);
          end
        end
      end
    end
  end

  assign lock_o = lock_q;
  assign err_o  = err_q;

  a_r9_disable_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (err_q == '0 && !lock_q));
  a_r8_miss_unlocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && have_q && !hit) |=> !lock_q);
  a_r8_err_saturates: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && err_q == ERR_MAX) |=> err_q == ERR_MAX);
  a_r7_lock_after_match: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lock_q) |-> $past(en_i && have_q && hit));
endmodule

// File: rtl/rx_lvds_deframer.sv
module rx_lvds_deframer
  import rx_deframe_pkg::*;
#(
  parameter int SMP_W    = SMP_W_DEF,
  parameter int NUM_CH   = NUM_CH_DEF,
  parameter int LOCK_RUN = LOCK_RUN_DEF,
  parameter int ERR_W    = ERR_W_DEF,
  localparam int HALF_W  = SMP_W / 2
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [HALF_W-1:0]       rx_rise_i,
  input  logic [HALF_W-1:0]       rx_fall_i,
  input  logic                    frame_rise_i,
  input  logic                    frame_fall_i,
  input  logic                    prbs_en_i,
  output logic [NUM_CH*SMP_W-1:0] ch_data_o,
  output logic [NUM_CH-1:0]       ch_valid_o,
  output logic                    align_o,
  output logic                    misalign_o,
  output logic                    prbs_lock_o,
  output logic [ERR_W-1:0]        prbs_err_o
);
  logic [SMP_W-1:0] word;
  logic             frame_valid;

  // rising-edge half is the upper half of the sample
  assign word = {rx_rise_i, rx_fall_i};

  rx_frame_align #(.SMP_W(SMP_W), .NUM_CH(NUM_CH)) i_align (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .word_i       (word),
    .frame_rise_i (frame_rise_i),
    .frame_fall_i (frame_fall_i),
    .data_o       (ch_data_o),
    .valid_o      (frame_valid),
    .align_o      (align_o),
    .misalign_o   (misalign_o)
  );

  assign ch_valid_o = {NUM_CH{frame_valid}};

  rx_prbs_mon #(
    .W        (SMP_W),
    .TAPS     (SMP_W'(PRBS_TAPS_DEF)),
    .LOCK_RUN (LOCK_RUN),
    .ERR_W    (ERR_W)
  ) i_prbs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (prbs_en_i),
    .word_i (word),
    .lock_o (prbs_lock_o),
    .err_o  (prbs_err_o)
  );
endmodule

// File: tb/test_rx_lvds_deframer.sv
`timescale 1ns/1ps
module test_rx_lvds_deframer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  rx_rise = '0, rx_fall = '0;
  logic        fr_r = 1'b0, fr_f = 1'b0, en = 1'b0;
  logic [47:0] ch_data;
  logic [3:0]  ch_valid;
  logic        align, misalign, lock;
  logic [15:0] err;

  always #2.5 clk = ~clk;

  rx_lvds_deframer i_rx_lvds_deframer (
    .clk_i(clk), .rst_ni(rst_n), .rx_rise_i(rx_rise), .rx_fall_i(rx_fall),
    .frame_rise_i(fr_r), .frame_fall_i(fr_f), .prbs_en_i(en),
    .ch_data_o(ch_data), .ch_valid_o(ch_valid), .align_o(align),
    .misalign_o(misalign), .prbs_lock_o(lock), .prbs_err_o(err)
  );

  int n_chk = 0, n_err = 0;
  bit done = 0;

  // reference state
  bit          m_al = 0, m_pf = 1, m_valid = 0, m_mis = 0;
  int          m_slot = 0;
  logic [11:0] m_buf [3];
  logic [47:0] m_out = '0;
  bit          m_have = 0, m_lock = 0;
  int          m_run = 0;
  logic [11:0] m_prev = '0;
  logic [15:0] m_err = '0;

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [11:0] lfsr12(logic [11:0] s);
    for (int k = 0; k < 12; k++) s = {s[10:0], s[11] ^ s[5] ^ s[3] ^ s[0]};
    return s;
  endfunction

  task automatic model(logic [11:0] w, bit r, bit f, bit e);
    bit hi;
    m_valid = 0;
    if (!m_al) begin
      if (r && f && !m_pf) begin m_al = 1; m_buf[0] = w; m_slot = 1; end
    end else begin
      hi = (m_slot < 2);
      if (r == hi && f == hi) begin
        if (m_slot == 3) begin
          m_out = {w, m_buf[2], m_buf[1], m_buf[0]}; m_valid = 1; m_slot = 0;
        end else begin m_buf[m_slot] = w; m_slot++; end
      end else begin m_mis = 1; m_al = 0; m_slot = 0; end
    end
    m_pf = f;
    if (!e) begin m_have = 0; m_run = 0; m_lock = 0; m_err = '0; end
    else begin
      if (m_have) begin
        if (w == lfsr12(m_prev)) begin
          if (m_run < 16) m_run++;
          m_lock = (m_run >= 16);
        end else begin
          m_run = 0; m_lock = 0;
          if (m_err != 16'hFFFF) m_err++;
        end
      end
      m_prev = w; m_have = 1;
    end
  endtask

  task automatic check_all();
    check("R4 strobe", 64'(ch_valid), m_valid ? 64'hF : 64'h0);
    check("R1 R3 channel data", 64'(ch_data), 64'(m_out));
    check("R5 misalign", 64'(misalign), 64'(m_mis));
    check("R6 align", 64'(align), 64'(m_al));
    check("R7 lock", 64'(lock), 64'(m_lock));
    check("R8 err count", 64'(err), 64'(m_err));
  endtask

  task automatic drive(logic [11:0] w, bit r, bit f, bit e);
    @(negedge clk);
    check_all();
    rx_rise = w[11:6]; rx_fall = w[5:0]; fr_r = r; fr_f = f; en = e;
    model(w, r, f, e);
  endtask

  task automatic frame4(logic [11:0] a, logic [11:0] b, logic [11:0] c, logic [11:0] d);
    drive(a, 1, 1, 0); drive(b, 1, 1, 0); drive(c, 0, 0, 0); drive(d, 0, 0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    logic [11:0] w;
    int          g;
    bit          r, f, e;
    void'($urandom(32'd1234));
    // R10 reset state
    repeat (3) begin @(negedge clk); check_all(); end
    @(negedge clk); rst_n = 1'b1; model('0, 0, 0, 0);

    // R2: frame already high is not an edge; half-sample edge rejected
    drive(12'h111, 0, 0, 0);
    drive(12'h222, 1, 0, 0);
    drive(12'h333, 0, 0, 0);
    // R1 R3 R4 clean frames
    frame4(12'hA5C, 12'h3F0, 12'h0C3, 12'hFFF);
    frame4(12'h001, 12'h800, 12'h7FE, 12'h456);
    // R5: violation in slot 2, partial frame dropped
    drive(12'h101, 1, 1, 0); drive(12'h202, 1, 1, 0); drive(12'h303, 1, 1, 0);
    drive(12'h404, 1, 1, 0);               // still high: no edge
    drive(12'h505, 0, 0, 0);
    frame4(12'h9AB, 12'hCDE, 12'h135, 12'h79B);
    // R5: half-sample frame on last slot
    drive(12'h606, 1, 1, 0); drive(12'h707, 1, 1, 0); drive(12'h808, 0, 0, 0);
    drive(12'h909, 0, 1, 0);
    drive(12'h0AA, 0, 0, 0);
    frame4(12'hBCD, 12'h123, 12'hEF0, 12'h5A5);

    // random framing with corruption and monitor enable toggles
    g = 0;
    for (int i = 0; i < 3000; i++) begin
      w = 12'($urandom);
      r = (g < 2); f = r;
      if ($urandom % 40 == 0) r = ~r;
      if ($urandom % 40 == 0) f = ~f;
      e = ($urandom % 8 != 0);
      drive(w, r, f, e);
      g = (g + 1) % 4;
    end

    // R9 clear then R7 lock on a true sequence, frames kept valid
    drive(12'h000, 0, 0, 0);
    w = 12'h5A3; g = 0;
    for (int i = 0; i < 60; i++) begin
      if (i == 40) drive(w ^ 12'h010, g < 2, g < 2, 1);  // R8 single error
      else drive(w, g < 2, g < 2, 1);
      w = lfsr12(w); g = (g + 1) % 4;
    end
    for (int i = 0; i < 40; i++) begin drive(w, 0, 0, 1); w = lfsr12(w); end
    drive(w, 0, 0, 0);                      // R9 disable clears
    drive(lfsr12(w), 0, 0, 1);              // R9 seed only
    // R8 saturation: all-ones never follows itself
    for (int i = 0; i < 66000; i++) drive(12'hFFF, 0, 0, 1);
    @(negedge clk); check_all();
    check("R8 saturated", 64'(err), 64'hFFFF);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule